// File: doc/BRIEF.md
# Destination Address Match Classifier

This block sits at the front of an Ethernet receive path and decides, for each incoming frame, whether its 48-bit destination address is wanted. The address arrives with a one-cycle strobe. The block applies a fixed chain of rules: promiscuous pass-through, broadcast, a 64-entry hash table, and a small bank of exact-match address slots. One clock later it reports whether the frame is accepted. It also reports a 32-bit flag word that a later receive DMA merges into word 1 of the frame's descriptors. That word records which rule let the frame in and, for an exact match, which slot it was.

Software programs the block through one write-data bus with a separate write strobe for each register: the low and high halves of each slot, and the low and high halves of the hash table. A slot is removed from matching when its low half is written. It is put back into matching when its high half is written, so a new address can be loaded in two writes without a window in which a half-updated address could match. The configuration bits are plain level inputs.

Address bit numbering: `da_addr[0]` is the first bit received on the wire. It is the group (multicast) indicator.

Top module: `da_match_classifier`

## Requirements
- R1: Rules are applied in this order: promiscuous, broadcast, hash, exact slots. With `cfg_promisc` high, every strobed address is accepted with a flag word of zero, whatever the other rules would decide.
- R2: An all-ones address is rejected when `cfg_bcast_reject` is high. Otherwise it is accepted with only flag bit 31 set. The later rules are not consulted for it.
- R3: The hash index bit k (k = 0..5) is the XOR of `da_addr[k + 6*j]` for j = 0..7. Table entries 0–31 are bits 31:0 of the value written with `hash_lo_we`. Entries 32–63 are bits 31:0 of the value written with `hash_hi_we`.
- R4: If the indexed table entry is set, the outcome depends on `da_addr[0]`. A multicast address (`da_addr[0]`=1) with `cfg_mcast_hash_en` high is accepted with only flag bit 30 set. A unicast address with `cfg_ucast_hash_en` high is accepted with only flag bit 29 set. A hash hit takes precedence over an exact slot match. When the matching enable is low, the address falls through to the slots.
- R5: Slot i holds `wr_data[31:0]` from its low write as address bits 31:0, and `wr_data[15:0]` from its high write as address bits 47:32. Among the armed slots that equal the address, the one with the highest index wins. The frame is accepted with flag bit 27 set, the slot index in bits 26:25, and every other flag bit zero.
- R6: A low-half write disarms its slot. A high-half write arms it. If both strobes for one slot are high in the same cycle, the slot ends up armed. Reset disarms all slots.
- R7: An address that no rule accepts is rejected. A rejected result always carries a flag word of zero.
- R8: `res_valid` is high for exactly the one cycle after each cycle in which `da_valid` is high. `res_accept` and `res_flags` change only at those edges.
- R9: Classification uses the register contents in effect before the strobe edge. A slot or table write in the same cycle as the strobe affects only later strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_promisc | input | 1 | Accept everything, with no flags |
| cfg_bcast_reject | input | 1 | Reject the all-ones address |
| cfg_mcast_hash_en | input | 1 | Allow hash acceptance of multicast addresses |
| cfg_ucast_hash_en | input | 1 | Allow hash acceptance of unicast addresses |
| wr_data | input | 32 | Write data shared by all register strobes |
| hash_lo_we | input | 1 | Write table entries 0–31 |
| hash_hi_we | input | 1 | Write table entries 32–63 |
| slot_lo_we | input | 4 | Per-slot low-half write (disarms the slot) |
| slot_hi_we | input | 4 | Per-slot high-half write (arms the slot) |
| da_valid | input | 1 | Destination address strobe |
| da_addr | input | 48 | Destination address, bit 0 first on the wire |
| res_valid | output | 1 | Result strobe, one cycle after `da_valid` |
| res_accept | output | 1 | 1 = accept, 0 = reject |
| res_flags | output | 32 | Descriptor word-1 flag bits |

## Verification
The embedded properties watch every cycle for the following:
- the one-cycle strobe latency;
- promiscuous acceptance with no flags;
- broadcast rejection when it is configured;
- zero flags on every rejection;
- at most one match class per result;
- a zero slot-index field whenever the slot-match bit is clear;
- the arm and disarm effect of each slot's half writes.

Only the directed scenarios can show the following:
- which armed slot wins when several hold the same address;
- that a hash hit overrides an exact match;
- that the fold sends an address to the table half and bit the bench computes;
- that a write made in the same cycle as a strobe is not yet seen.

// File: rtl/da_cls_pkg.sv
package da_cls_pkg;
   localparam int FLAG_W     = 32;
   localparam int BCAST_BIT  = 31;
   localparam int MHASH_BIT  = 30;
   localparam int UHASH_BIT  = 29;
   localparam int SMATCH_BIT = 27;
   localparam int SIDX_LSB   = 25;
   localparam int SIDX_W     = 2;
endpackage

// File: rtl/da_slot_bank.sv
module da_slot_bank #(
   parameter int NUM_SLOTS = 4,
   parameter int ADDR_W    = 48,
   parameter int DATA_W    = 32,
   parameter int IDX_W     = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic [NUM_SLOTS-1:0] lo_we,
   input  logic [NUM_SLOTS-1:0] hi_we,
   input  logic [ADDR_W-1:0]    da_addr,
   output logic                 hit,
   output logic [IDX_W-1:0]     hit_idx
);
   localparam int LO_W = DATA_W;
   localparam int HI_W = ADDR_W - DATA_W;

   if (NUM_SLOTS < 1 || NUM_SLOTS > (1 << IDX_W)) begin : g_bad_slots
      $error("da_slot_bank: NUM_SLOTS must be 1..2**IDX_W");
   end
   if (HI_W < 1 || HI_W > DATA_W) begin : g_bad_width
      $error("da_slot_bank: ADDR_W must lie in (DATA_W, 2*DATA_W]");
   end

   logic [LO_W-1:0]      lo_q [NUM_SLOTS];
   logic [HI_W-1:0]      hi_q [NUM_SLOTS];
   logic [NUM_SLOTS-1:0] armed;
   logic [NUM_SLOTS-1:0] match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= '0;
         for (int s = 0; s < NUM_SLOTS; s++) begin
            lo_q[s] <= '0;
            hi_q[s] <= '0;
         end
      end else begin
         for (int s = 0; s < NUM_SLOTS; s++) begin
            if (lo_we[s]) begin
               lo_q[s]  <= wr_data;
               armed[s] <= 1'b0;
            end
            if (hi_we[s]) begin
               hi_q[s]  <= wr_data[HI_W-1:0];
               armed[s] <= 1'b1;
            end
         end
      end
   end

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      assign match[g] = armed[g] && ({hi_q[g], lo_q[g]} == da_addr);

      AST_SLOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
         (lo_we[g] && !hi_we[g]) |=> !armed[g]); // R6
      AST_SLOT_ARM: assert property (@(posedge clk) disable iff (!rst_n)
         hi_we[g] |=> armed[g]); // R6
   end

   always_comb begin
      hit     = 1'b0;
      hit_idx = '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         if (match[s]) begin
            hit     = 1'b1;
            hit_idx = s[IDX_W-1:0];
         end
      end
   end
endmodule

// File: rtl/da_hash_lookup.sv
module da_hash_lookup #(
   parameter int ADDR_W = 48,
   parameter int DATA_W = 32,
   parameter int HIDX_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              lo_we,
   input  logic              hi_we,
   input  logic [ADDR_W-1:0] da_addr,
   output logic              hit
);
   localparam int TBL_N = 1 << HIDX_W;

   if (TBL_N != 2 * DATA_W) begin : g_bad_table
      $error("da_hash_lookup: table must be exactly two data words");
   end

   logic [DATA_W-1:0] tbl_lo, tbl_hi;
   logic [TBL_N-1:0]  tbl;
   logic [HIDX_W-1:0] idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tbl_lo <= '0;
         tbl_hi <= '0;
      end else begin
         if (lo_we) tbl_lo <= wr_data;
         if (hi_we) tbl_hi <= wr_data;
      end
   end

   always_comb begin
      idx = '0;
      for (int b = 0; b < ADDR_W; b++) begin
         idx[b % HIDX_W] = idx[b % HIDX_W] ^ da_addr[b];
      end
   end

   assign tbl = {tbl_hi, tbl_lo};
   assign hit = tbl[idx];
endmodule

// File: rtl/da_cls_decide.sv
module da_cls_decide
   import da_cls_pkg::*;
#(
   parameter int ADDR_W = 48
) (
   input  logic              cfg_promisc,
   input  logic              cfg_bcast_reject,
   input  logic              cfg_mcast_hash_en,
   input  logic              cfg_ucast_hash_en,
   input  logic [ADDR_W-1:0] da_addr,
   input  logic              hash_hit,
   input  logic              slot_hit,
   input  logic [SIDX_W-1:0] slot_idx,
   output logic              accept,
   output logic [FLAG_W-1:0] flags
);
   logic is_bcast, is_mcast;
   assign is_bcast = &da_addr;
   assign is_mcast = da_addr[0];

   always_comb begin
      accept = 1'b0;
      flags  = '0;
      if (cfg_promisc) begin
         accept = 1'b1;
      end else if (is_bcast) begin
         if (!cfg_bcast_reject) begin
            accept           = 1'b1;
            flags[BCAST_BIT] = 1'b1;
         end
      end else if (hash_hit && is_mcast && cfg_mcast_hash_en) begin
         accept           = 1'b1;
         flags[MHASH_BIT] = 1'b1;
      end else if (hash_hit && !is_mcast && cfg_ucast_hash_en) begin
         accept           = 1'b1;
         flags[UHASH_BIT] = 1'b1;
      end else if (slot_hit) begin
         accept                          = 1'b1;
         flags[SMATCH_BIT]               = 1'b1;
         flags[SIDX_LSB +: SIDX_W]       = slot_idx;
      end
   end
endmodule

// File: rtl/da_match_classifier.sv
module da_match_classifier
   import da_cls_pkg::*;
#(
   parameter int NUM_SLOTS = 4,
   parameter int ADDR_W    = 48,
   parameter int DATA_W    = 32,
   parameter int HIDX_W    = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_promisc,
   input  logic                 cfg_bcast_reject,
   input  logic                 cfg_mcast_hash_en,
   input  logic                 cfg_ucast_hash_en,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic                 hash_lo_we,
   input  logic                 hash_hi_we,
   input  logic [NUM_SLOTS-1:0] slot_lo_we,
   input  logic [NUM_SLOTS-1:0] slot_hi_we,
   input  logic                 da_valid,
   input  logic [ADDR_W-1:0]    da_addr,
   output logic                 res_valid,
   output logic                 res_accept,
   output logic [FLAG_W-1:0]    res_flags
);
   logic              hash_hit, slot_hit, nx_accept;
   logic [SIDX_W-1:0] slot_idx;
   logic [FLAG_W-1:0] nx_flags;

   da_slot_bank #(
      .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(SIDX_W)
   ) u_slots (
      .clk(clk), .rst_n(rst_n), .wr_data(wr_data),
      .lo_we(slot_lo_we), .hi_we(slot_hi_we), .da_addr(da_addr),
      .hit(slot_hit), .hit_idx(slot_idx)
   );

   da_hash_lookup #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HIDX_W(HIDX_W)
   ) u_hash (
      .clk(clk), .rst_n(rst_n), .wr_data(wr_data),
      .lo_we(hash_lo_we), .hi_we(hash_hi_we), .da_addr(da_addr),
      .hit(hash_hit)
   );

   da_cls_decide #(.ADDR_W(ADDR_W)) u_decide (
      .cfg_promisc(cfg_promisc), .cfg_bcast_reject(cfg_bcast_reject),
      .cfg_mcast_hash_en(cfg_mcast_hash_en), .cfg_ucast_hash_en(cfg_ucast_hash_en),
      .da_addr(da_addr), .hash_hit(hash_hit), .slot_hit(slot_hit),
      .slot_idx(slot_idx), .accept(nx_accept), .flags(nx_flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_accept <= 1'b0;
         res_flags  <= '0;
      end else begin
         res_valid <= da_valid;
         if (da_valid) begin
            res_accept <= nx_accept;
            res_flags  <= nx_flags;
         end
      end
   end

   AST_PROMISC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid && cfg_promisc) |=> (res_valid && res_accept && res_flags == '0)); // R1
   AST_BCAST_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid && !cfg_promisc && (&da_addr) && cfg_bcast_reject) |=> !res_accept); // R2
   AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $onehot0({res_flags[BCAST_BIT], res_flags[MHASH_BIT],
                              res_flags[UHASH_BIT], res_flags[SMATCH_BIT]})); // R4
   AST_IDX_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_flags[SMATCH_BIT]) |-> res_flags[SIDX_LSB +: SIDX_W] == '0); // R5
   AST_REJECT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_accept) |-> res_flags == '0); // R7
   AST_STROBE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      da_valid |=> res_valid); // R8
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !da_valid |=> !res_valid); // R8
endmodule

// File: tb/da_match_classifier_bench.sv
module da_match_classifier_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_promisc = 0, cfg_bcast_reject = 0;
   logic        cfg_mcast_hash_en = 0, cfg_ucast_hash_en = 0;
   logic [31:0] wr_data = '0;
   logic        hash_lo_we = 0, hash_hi_we = 0;
   logic [3:0]  slot_lo_we = '0, slot_hi_we = '0;
   logic        da_valid = 0;
   logic [47:0] da_addr = '0;
   logic        res_valid, res_accept;
   logic [31:0] res_flags;

   int tests = 0, fails = 0;
   bit done = 0;

   always #5 clk = ~clk;

   da_match_classifier u_da_match_classifier (
      .clk(clk), .rst_n(rst_n),
      .cfg_promisc(cfg_promisc), .cfg_bcast_reject(cfg_bcast_reject),
      .cfg_mcast_hash_en(cfg_mcast_hash_en), .cfg_ucast_hash_en(cfg_ucast_hash_en),
      .wr_data(wr_data), .hash_lo_we(hash_lo_we), .hash_hi_we(hash_hi_we),
      .slot_lo_we(slot_lo_we), .slot_hi_we(slot_hi_we),
      .da_valid(da_valid), .da_addr(da_addr),
      .res_valid(res_valid), .res_accept(res_accept), .res_flags(res_flags)
   );

   localparam logic [47:0] ADDR_A = 48'hA1B2_C3D4_E5F6;
   localparam logic [47:0] ADDR_B = 48'h0102_0304_0506;
   localparam logic [47:0] ADDR_C = 48'h4455_6677_8890;
   localparam logic [47:0] ADDR_D = 48'h7788_0000_7788;
   localparam logic [47:0] ADDR_M = 48'h0000_5E00_0001;

   function automatic logic [31:0] slot_flags(input int i);
      return 32'h0800_0000 | (32'(i) << 25);
   endfunction

   function automatic int fold_idx(input logic [47:0] a);
      logic [5:0] r = '0;
      for (int k = 0; k < 6; k++)
         for (int j = 0; j < 8; j++) r[k] = r[k] ^ a[k + 6*j];
      return int'(r);
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_slot(input int s, input logic lo, input logic hi, input logic [31:0] d);
      @(negedge clk);
      wr_data = d;
      slot_lo_we[s] = lo;
      slot_hi_we[s] = hi;
      @(negedge clk);
      slot_lo_we = '0;
      slot_hi_we = '0;
   endtask

   task automatic load_slot(input int s, input logic [47:0] a);
      wr_slot(s, 1, 0, a[31:0]);
      wr_slot(s, 0, 1, {16'h0, a[47:32]});
   endtask

   task automatic wr_hash(input logic hi, input logic [31:0] d);
      @(negedge clk);
      wr_data = d;
      hash_lo_we = !hi;
      hash_hi_we = hi;
      @(negedge clk);
      hash_lo_we = 0;
      hash_hi_we = 0;
   endtask

   // Strobe one address and check the registered result at the next negedge.
   task automatic classify(input string req, input logic [47:0] a,
                           input logic exp_acc, input logic [31:0] exp_fl);
      @(negedge clk);
      da_addr = a;
      da_valid = 1;
      @(negedge clk);
      da_valid = 0;
      check({req, " valid"}, 64'(res_valid), 64'd1);
      check({req, " accept"}, 64'(res_accept), 64'(exp_acc));
      check({req, " flags"}, 64'(res_flags), 64'(exp_fl));
   endtask

   task automatic t_reset;
      check("R8 reset valid", 64'(res_valid), 0);
      check("R8 reset accept", 64'(res_accept), 0);
      check("R8 reset flags", 64'(res_flags), 0);
      classify("R6 no slot armed after reset", 48'h0, 0, 0);
      @(negedge clk);
      check("R8 valid one cycle only", 64'(res_valid), 0);
      check("R8 flags hold", 64'(res_flags), 0);
   endtask

   task automatic t_slots;
      load_slot(2, ADDR_A);
      classify("R5 slot 2 match", ADDR_A, 1, slot_flags(2));
      load_slot(1, ADDR_B);
      load_slot(3, ADDR_B);
      classify("R5 highest slot wins", ADDR_B, 1, slot_flags(3));
      wr_slot(3, 1, 0, ADDR_B[31:0]);
      classify("R6 low write disarms", ADDR_B, 1, slot_flags(1));
      wr_slot(3, 1, 1, 32'h0000_7788);
      classify("R6 both strobes arm", ADDR_D, 1, slot_flags(3));
      classify("R7 no match rejects", ADDR_C, 0, 0);
   endtask

   task automatic t_same_cycle;
      wr_slot(0, 1, 0, ADDR_C[31:0]);
      @(negedge clk);
      wr_data = {16'h0, ADDR_C[47:32]};
      slot_hi_we[0] = 1;
      da_addr = ADDR_C;
      da_valid = 1;
      @(negedge clk);
      slot_hi_we = '0;
      da_valid = 0;
      check("R9 same-cycle arm unseen", 64'(res_accept), 0);
      classify("R9 arm seen later", ADDR_C, 1, slot_flags(0));
   endtask

   task automatic t_bcast;
      classify("R2 broadcast accept", 48'hFFFF_FFFF_FFFF, 1, 32'h8000_0000);
      cfg_bcast_reject = 1;
      classify("R2 broadcast reject", 48'hFFFF_FFFF_FFFF, 0, 0);
      cfg_promisc = 1;
      classify("R1 promisc beats bcast reject", 48'hFFFF_FFFF_FFFF, 1, 0);
      classify("R1 promisc over slot", ADDR_A, 1, 0);
      cfg_promisc = 0;
      cfg_bcast_reject = 0;
   endtask

   task automatic t_hash;
      int im = fold_idx(ADDR_M);
      int ia = fold_idx(ADDR_A);
      logic [63:0] tbl = '0;
      tbl[im] = 1'b1;
      tbl[ia] = 1'b1;
      wr_hash(0, tbl[31:0]);
      wr_hash(1, tbl[63:32]);
      classify("R4 mcast hash disabled", ADDR_M, 0, 0);
      cfg_mcast_hash_en = 1;
      classify("R3 R4 mcast hash hit", ADDR_M, 1, 32'h4000_0000);
      if (fold_idx(ADDR_M ^ 48'h2) != ia)
         classify("R3 other index misses", ADDR_M ^ 48'h2, 0, 0);
      classify("R4 ucast off falls to slot", ADDR_A, 1, slot_flags(2));
      cfg_ucast_hash_en = 1;
      classify("R4 ucast hash beats slot", ADDR_A, 1, 32'h2000_0000);
      cfg_mcast_hash_en = 0;
      cfg_ucast_hash_en = 0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_slots();
      t_same_cycle();
      t_bcast();
      t_hash();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule